// File: doc/BRIEF.md
# Message-Object Staging and Transfer Engine

This block sits between a simple CPU register bus and an internal array of 32 message objects, the storage a CAN controller uses for frames waiting to be sent or frames already received. Software never touches an object directly. It fills a set of staging registers (acceptance mask, arbitration word, message control, two data words). It then writes one command word that names an object and says which field groups to move and in which direction. The engine copies those groups between the staging registers and the object and shows a busy flag while it works.

A copy toward the object can also raise the object's transmit-request flag. A copy toward the staging registers can clear the object's interrupt-pending and new-data flags as a side effect. The staging registers always receive the values from before the clear, so software sees what was pending. Command writes that name no real object are dropped without any transfer. Writes to any register are ignored while a transfer runs.

Top module: `msg_obj_port`

## Requirements
- R1: After reset the busy output is 0 and every register read (command at address 0, mask 1, arbitration 2, control 3, data A 4, data B 5) returns 0.
- R2: Reading the command register returns the last accepted command mask in bits 23:16, the busy flag in bit 15 and the object number in bits 5:0, with every other bit 0.
- R3: A command write whose object number (bits 5:0) is 1 to 32 sets busy on the next cycle, and busy stays set for exactly two cycles.
- R4: A command write with object number 0 or above 32 starts no transfer: busy stays 0, and no object or staging register changes.
- R5: With command bit 7 set (toward the object), each selected group is copied from staging to the object: bit 6 mask, bit 5 arbitration, bit 4 control, bit 1 data A, bit 0 data B. Groups not selected stay as they were.
- R6: A transfer toward the object with bit 2 set sets the transmit-request flag (control bit 8) in the object; if bit 4 is clear, the other control bits of the object are kept. Bit 3 has no effect in this direction.
- R7: With command bit 7 clear (toward staging), each selected group (same bit positions as R5) is copied from the object into staging. Staging registers not selected keep their values.
- R8: A transfer toward staging with bit 3 set clears interrupt-pending (control bit 13) in the object, and with bit 2 set clears new-data (control bit 15). The staging control register receives the value from before the clear.
- R9: While busy is set, writes to any register, including the command register, are ignored.
- R10: The control staging register is 16 bits wide; bits 31:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 3 | Register address (0 command, 1 mask, 2 arbitration, 3 control, 4 data A, 5 data B) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| xfer_busy | output | 1 | High while a transfer is in progress |

## Verification
A command accepted at clock edge k raises busy right after that edge. The object is read at edge k+1, and both the object and the staging registers are written at edge k+2, after which busy is low. Read data is registered, so a read strobed in one cycle returns the value that held before the next edge. The bench therefore checks busy at the falling edge after each edge. It expects busy bits of 1, 1, 0 from three back-to-back command reads. It waits two full cycles after each command before comparing staging and object contents against its own arithmetic model.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
  // Command mask bit positions (bits 23:16 of the command word)
  localparam int CM_TOWARD_OBJ = 7;
  localparam int CM_MASK       = 6;
  localparam int CM_ARB        = 5;
  localparam int CM_CTL        = 4;
  localparam int CM_CLR_INT    = 3;
  localparam int CM_TXREQ_NEW  = 2;
  localparam int CM_DATA_A     = 1;
  localparam int CM_DATA_B     = 0;

  // Message control bit positions
  localparam int CTL_NEWDATA   = 15;
  localparam int CTL_INTPEND   = 13;
  localparam int CTL_TXREQ     = 8;

  // Field groups, staging register at bus address index + 1
  localparam int NFIELD  = 5;
  localparam int F_MASK  = 0;
  localparam int F_ARB   = 1;
  localparam int F_CTL   = 2;
  localparam int F_DA    = 3;
  localparam int F_DB    = 4;

  typedef enum logic [1:0] {
    X_IDLE  = 2'd0,
    X_FETCH = 2'd1,
    X_APPLY = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/msgobj_field_ram.sv
module msgobj_field_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/msgobj_xfer_seq.sv
module msgobj_xfer_seq
  import msgobj_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic apply
);
  xfer_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= X_IDLE;
    end else begin
      case (st)
        X_IDLE:  if (start) st <= X_FETCH;
        X_FETCH: st <= X_APPLY;
        default: st <= X_IDLE;
      endcase
    end
  end

  assign busy  = (st != X_IDLE);
  assign apply = (st == X_APPLY);
endmodule

// File: rtl/msg_obj_port.sv
module msg_obj_port
  import msgobj_pkg::*;
#(
  parameter int OBJ_NUM = 32,
  parameter int DW      = 32,
  parameter int CTLW    = 16,
  parameter int ABW     = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [ABW-1:0] bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           xfer_busy
);
  localparam int NUM_W = $clog2(OBJ_NUM + 1);
  localparam int IDX_W = $clog2(OBJ_NUM);
  localparam logic [DW-1:0] CTL_KEEP = {{(DW-CTLW){1'b0}}, {CTLW{1'b1}}};

  logic [7:0]       cmd_mask;
  logic [NUM_W-1:0] cmd_obj;
  logic [IDX_W-1:0] obj_idx;
  logic [NUM_W-1:0] w_obj;
  logic             cmd_wr, obj_ok, start;
  logic             busy, apply;
  logic [NFIELD-1:0] sel;
  logic [NFIELD-1:0] ram_we;
  logic [DW-1:0]    ram_wd [NFIELD];
  logic [DW-1:0]    ram_q  [NFIELD];
  logic [DW-1:0]    stg    [NFIELD];
  logic [31:0]      rd_mux;

  assign w_obj  = bus_wdata[NUM_W-1:0];
  assign cmd_wr = bus_wr && !busy && (bus_addr == '0);
  assign obj_ok = (w_obj != '0) && (w_obj <= NUM_W'(OBJ_NUM));
  assign start  = cmd_wr && obj_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_mask <= '0;
      cmd_obj  <= '0;
      obj_idx  <= '0;
    end else if (cmd_wr) begin
      cmd_mask <= bus_wdata[23:16];
      cmd_obj  <= w_obj;
      obj_idx  <= IDX_W'(w_obj - NUM_W'(1));
    end
  end

  msgobj_xfer_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .apply (apply)
  );

  assign sel = {cmd_mask[CM_DATA_B], cmd_mask[CM_DATA_A], cmd_mask[CM_CTL],
                cmd_mask[CM_ARB], cmd_mask[CM_MASK]};

  // Object-side write data; control is read-modify-write
  always_comb begin
    for (int f = 0; f < NFIELD; f++) begin
      ram_we[f] = 1'b0;
      ram_wd[f] = stg[f];
    end
    if (apply) begin
      if (cmd_mask[CM_TOWARD_OBJ]) begin
        for (int f = 0; f < NFIELD; f++)
          if (f != F_CTL) ram_we[f] = sel[f];
        ram_we[F_CTL] = cmd_mask[CM_CTL] | cmd_mask[CM_TXREQ_NEW];
        ram_wd[F_CTL] = cmd_mask[CM_CTL] ? stg[F_CTL] : ram_q[F_CTL];
        if (cmd_mask[CM_TXREQ_NEW]) ram_wd[F_CTL][CTL_TXREQ] = 1'b1;
      end else begin
        ram_we[F_CTL] = cmd_mask[CM_CLR_INT] | cmd_mask[CM_TXREQ_NEW];
        ram_wd[F_CTL] = ram_q[F_CTL];
        if (cmd_mask[CM_CLR_INT])   ram_wd[F_CTL][CTL_INTPEND] = 1'b0;
        if (cmd_mask[CM_TXREQ_NEW]) ram_wd[F_CTL][CTL_NEWDATA] = 1'b0;
      end
    end
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam logic [DW-1:0] KEEP = (f == F_CTL) ? CTL_KEEP : {DW{1'b1}};
    logic host_we;
    assign host_we = bus_wr && !busy && (bus_addr == ABW'(f + 1));

    always_ff @(posedge clk) begin
      if (rst)
        stg[f] <= '0;
      else if (host_we)
        stg[f] <= bus_wdata[DW-1:0] & KEEP;
      else if (apply && !cmd_mask[CM_TOWARD_OBJ] && sel[f])
        stg[f] <= ram_q[f];
    end

    msgobj_field_ram #(.DEPTH(OBJ_NUM), .W(DW)) u_ram (
      .clk   (clk),
      .we    (ram_we[f]),
      .waddr (obj_idx),
      .wdata (ram_wd[f]),
      .raddr (obj_idx),
      .rdata (ram_q[f])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == '0)
      rd_mux = {8'h00, cmd_mask, busy, {(15-NUM_W){1'b0}}, cmd_obj};
    for (int f = 0; f < NFIELD; f++)
      if (bus_addr == ABW'(f + 1)) rd_mux = 32'(stg[f]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign xfer_busy = busy;
endmodule

// File: rtl/msg_obj_port_chk.sv
module msg_obj_port_chk #(
  parameter int OBJ_NUM = 32,
  parameter int NUM_W   = 6,
  parameter int ABW     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [ABW-1:0]   bus_addr,
  input logic [NUM_W-1:0] w_obj,
  input logic             xfer_busy,
  input logic [7:0]       cmd_mask,
  input logic [31:0]      stg_mask
);
  logic [2:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)            busy_run <= '0;
    else if (!xfer_busy) busy_run <= '0;
    else if (busy_run != 3'd7) busy_run <= busy_run + 3'd1;
  end

  AST_VALID_START: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && !xfer_busy && w_obj != '0 && w_obj <= NUM_W'(OBJ_NUM)) |=> xfer_busy); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 3'd2); // R3
  AST_BAD_OBJ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && !xfer_busy && (w_obj == '0 || w_obj > NUM_W'(OBJ_NUM))) |=> !xfer_busy); // R4
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && bus_wr && bus_addr == '0) |=> $stable(cmd_mask)); // R9
  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && cmd_mask[7] && bus_wr && bus_addr == ABW'(1)) |=> $stable(stg_mask)); // R9
endmodule

bind msg_obj_port msg_obj_port_chk #(.OBJ_NUM(OBJ_NUM), .NUM_W(NUM_W), .ABW(ABW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .w_obj     (bus_wdata[NUM_W-1:0]),
  .xfer_busy (xfer_busy),
  .cmd_mask  (cmd_mask),
  .stg_mask  (32'(stg[0]))
);

// File: tb/msg_obj_port_test.sv
module msg_obj_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        xfer_busy;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mo [NOBJ][5];
  logic [31:0] ms [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_obj_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xfer_busy(xfer_busy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int n, input int f);
    logic [31:0] v;
    v = 32'h9E3779B9 * (n * 8 + f + 1);
    return v ^ 32'h5A00_00C3;
  endfunction

  task automatic set_stg(input int seed);
    for (int f = 0; f < 5; f++) begin
      logic [31:0] v;
      v = pat(seed, f);
      if (f == 2) v = (v | 32'h0000_A000) & 32'h0000_FFFF; // keep NEWDAT/INTPND set
      wr(3'(f + 1), (f == 2) ? (v | 32'hFFFF_0000) : v);
      ms[f] = v;
    end
  endtask

  task automatic model_cmd(input logic [7:0] cm, input int num);
    int i;
    logic [31:0] old [5];
    if (num == 0 || num > NOBJ) return;
    i = num - 1;
    if (cm[7]) begin
      if (cm[6]) mo[i][0] = ms[0];
      if (cm[5]) mo[i][1] = ms[1];
      if (cm[1]) mo[i][3] = ms[3];
      if (cm[0]) mo[i][4] = ms[4];
      if (cm[4]) mo[i][2] = ms[2];
      if (cm[2]) mo[i][2] = mo[i][2] | 32'h100;
    end else begin
      for (int f = 0; f < 5; f++) old[f] = mo[i][f];
      if (cm[6]) ms[0] = old[0];
      if (cm[5]) ms[1] = old[1];
      if (cm[4]) ms[2] = old[2];
      if (cm[1]) ms[3] = old[3];
      if (cm[0]) ms[4] = old[4];
      if (cm[3]) mo[i][2] = mo[i][2] & ~32'h2000;
      if (cm[2]) mo[i][2] = mo[i][2] & ~32'h8000;
    end
  endtask

  task automatic do_cmd(input logic [7:0] cm, input int num);
    wr(3'd0, {8'h00, cm, 10'h000, 6'(num)});
    model_cmd(cm, num);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify_stg(input string tag);
    logic [31:0] d;
    for (int f = 0; f < 5; f++) begin
      rd(3'(f + 1), d);
      chk(tag, d, ms[f]);
    end
  endtask

  task automatic verify_obj(input int num, input string tag);
    do_cmd(8'h73, num);
    verify_stg(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NOBJ; n++)
      for (int f = 0; f < 5; f++) mo[n][f] = '0;
    for (int f = 0; f < 5; f++) ms[f] = '0;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'b0, xfer_busy}, 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 32'h0);
    end

    // R10: control staging upper bits
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d);
    chk("R10 ctl width", d, 32'h0000_FFFF);

    // R5: fill every object, R7: read each back
    for (int n = 1; n <= NOBJ; n++) begin
      set_stg(n);
      do_cmd(8'hF3, n);
    end
    for (int n = 1; n <= NOBJ; n++) verify_obj(n, "R5/R7 fill");

    // R3/R2: busy timing and command readback
    wr(3'd0, {8'h00, 8'h40, 10'h000, 6'd7});
    model_cmd(8'h40, 7);
    chk("R3 busy c1", {31'b0, xfer_busy}, 32'h1);
    rd(3'd0, d);
    chk("R3 R2 cmd c1", d, {8'h00, 8'h40, 1'b1, 9'h0, 6'd7});
    chk("R3 busy c2", {31'b0, xfer_busy}, 32'h1);
    rd(3'd0, d);
    chk("R3 R2 cmd c2", d, {8'h00, 8'h40, 1'b1, 9'h0, 6'd7});
    chk("R3 busy done", {31'b0, xfer_busy}, 32'h0);
    rd(3'd0, d);
    chk("R2 cmd idle", d, {8'h00, 8'h40, 1'b0, 9'h0, 6'd7});
    verify_stg("R7 single");

    // R5 R6 R7 R8: sweep every command mask
    for (int c = 0; c < 256; c++) begin
      int n;
      n = (c % NOBJ) + 1;
      if (c[7] == 1'b0) begin
        set_stg(c + 500);
        do_cmd(8'h90, n); // load control with NEWDAT/INTPND set
      end
      set_stg(c + 1000);
      do_cmd(8'(c), n);
      verify_stg(c[7] ? "R5/R6 sweep stg" : "R7/R8 sweep stg");
      verify_obj(n, c[7] ? "R5/R6 sweep obj" : "R7/R8 sweep obj");
    end

    // R4: invalid object numbers
    for (int k = 0; k < 4; k++) begin
      int bad;
      bad = (k == 0) ? 0 : (k == 1) ? 33 : (k == 2) ? 47 : 63;
      set_stg(2000 + k);
      wr(3'd0, {8'h00, 8'hF7, 10'h000, 6'(bad)});
      chk("R4 no busy", {31'b0, xfer_busy}, 32'h0);
      @(negedge clk);
      @(negedge clk);
      verify_stg("R4 staging after write cmd");
      wr(3'd0, {8'h00, 8'h7F, 10'h000, 6'(bad)});
      chk("R4 no busy rd", {31'b0, xfer_busy}, 32'h0);
      @(negedge clk);
      @(negedge clk);
      verify_stg("R4 staging after read cmd");
      verify_obj(1, "R4 obj1");
      verify_obj(NOBJ, "R4 obj32");
    end

    // R9: writes during busy ignored
    set_stg(3000);
    wr(3'd0, {8'h00, 8'hC0, 10'h000, 6'd5});
    model_cmd(8'hC0, 5);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd0, {8'h00, 8'h73, 10'h000, 6'd9});
    @(negedge clk);
    rd(3'd0, d);
    chk("R9 cmd held", d, {8'h00, 8'hC0, 1'b0, 9'h0, 6'd5});
    rd(3'd1, d);
    chk("R9 staging held", d, ms[0]);
    verify_obj(5, "R9 obj");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule